// File: doc/BRIEF.md
# Shared-Function GPIO Port with Selectable Open-Drain Drive

This block is a five-pin bidirectional port whose pins are shared with on-chip peripherals: external interrupt inputs, a clock-divider output, a UART transmit and receive pair, and a serial bus. Each pin has three writable controls: a data latch, a drive-stage selector that picks push-pull or open-drain drive, and a pull-up enable. Software reaches these controls through a small synchronous write, combinational read register bus. A fourth, read-only address returns the synchronized level of the pins themselves, so the value software wrote and the level on the wire can be told apart.

A peripheral that wants a pin asserts its per-bit alternate-select line and supplies its output bit. The pin then carries the peripheral bit ANDed with the latch, so the latch must be left at 1 for the peripheral to reach the pad. A pin used as an input is left released: the latch is 1 and the drive stage is open-drain, and an outside source sets the level. The pad itself is modelled as an output-enable, an output value and a weak pull-up flag.

While the stop input is high, every pin is released, and the input synchronizer freezes so that the interrupt and receive inputs do not change.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every latch bit reads 1, every drive-stage bit reads 0, every pull-up bit reads 0, and no pin is driven (pad_oe = 0).
- R2: A write strobe with reg_addr 0 (latch), 1 (drive stage) or 2 (pull-up) loads reg_wdata into that register on the next rising clock edge. reg_rdata returns the addressed register combinationally.
- R3: When a drive-stage bit is 0 (open-drain), the pin is driven low (pad_oe=1, pad_out=0) when its data bit is 0 and is released (pad_oe=0, pad_out=0) when its data bit is 1.
- R4: When a drive-stage bit is 1 (push-pull), the pin is always driven (pad_oe=1) and pad_out equals its data bit.
- R5: pad_pullup equals the pull-up register bit by bit.
- R6: Reading address 0 returns the latch contents even when the pin level differs from it.
- R7: Reading address 3 returns the pin level after two rising clock edges of synchronization. The same synchronized value appears on sync_in.
- R8: A pin's data bit is the latch bit when its alt_sel bit is 0, and alt_out AND the latch bit when alt_sel is 1.
- R9: While stop_mode is 1, every pad_oe and pad_out bit is 0 whatever the registers hold.
- R10: While stop_mode is 1, the synchronized pin value (sync_in and address 3) does not change. It resumes tracking two edges after stop_mode falls.
- R11: A write to address 3 changes none of the latch, drive-stage or pull-up registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register select: 0 latch, 1 drive stage, 2 pull-up, 3 pin level |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Read data of the addressed register |
| alt_sel | input | 5 | Per-pin peripheral output select |
| alt_out | input | 5 | Per-pin peripheral output value |
| stop_mode | input | 1 | Stop: release all pins and freeze input sampling |
| pad_in | input | 5 | Level seen at each pad |
| pad_oe | output | 5 | Pad output enable |
| pad_out | output | 5 | Pad output value |
| pad_pullup | output | 5 | Weak pull-up enable per pad |
| sync_in | output | 5 | Synchronized pin level for peripheral inputs |

## Verification
The bench sweeps all 1024 combinations of latch and drive stage against four alternate-function patterns. A design that drives high in open-drain, or that ignores the latch gate on peripheral output, fails at once. It forces a pad low under a latch of 1 to catch a readback that returns the pin instead of the latch. It checks the pin register one edge after a change, so a one-flop or zero-flop path is caught. It changes the pads during stop, so an input path that keeps sampling is caught. It writes to the read-only address and then reads back all three control registers.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LATCH = 2'd0,
    SEL_STAGE = 2'd1,
    SEL_PULL  = 2'd2,
    SEL_PIN   = 2'd3
  } reg_sel_e;

  // Data bit presented to the output stage.
  function automatic logic pin_data(input logic use_alt, input logic alt_bit,
                                    input logic latch_bit);
    return use_alt ? (alt_bit & latch_bit) : latch_bit;
  endfunction

  // Returns {oe, out} for one pin.
  function automatic logic [1:0] drive_stage(input logic push_pull,
                                             input logic data,
                                             input logic stop);
    if (stop)           return 2'b00;
    else if (push_pull) return {1'b1, data};
    else                return {~data, 1'b0};
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WIDTH-1:0]    wdata,
  output logic [WIDTH-1:0]    latch_q,
  output logic [WIDTH-1:0]    stage_q,
  output logic [WIDTH-1:0]    pull_q
);
  logic wr_latch, wr_stage, wr_pull;

  assign wr_latch = wr && (addr == SEL_LATCH);
  assign wr_stage = wr && (addr == SEL_STAGE);
  assign wr_pull  = wr && (addr == SEL_PULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      stage_q <= '0;
      pull_q  <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_stage) stage_q <= wdata;
      if (wr_pull)  pull_q  <= wdata;
    end
  end

  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> latch_q == $past(wdata));
  assert_stage_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stage |=> stage_q == $past(wdata));
  assert_pin_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SEL_PIN) |=> ($stable(latch_q) && $stable(stage_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] stage_q,
  input  logic [WIDTH-1:0] alt_sel,
  input  logic [WIDTH-1:0] alt_out,
  input  logic             stop,
  output logic [WIDTH-1:0] data_bits,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [1:0] st;
    assign data_bits[i] = pin_data(alt_sel[i], alt_out[i], latch_q[i]);
    assign st           = drive_stage(stage_q[i], data_bits[i], stop);
    assign oe[i]        = st[1];
    assign out[i]       = st[0];
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
    end else if (!hold) begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

  assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] alt_sel,
  input  logic [WIDTH-1:0] alt_out,
  input  logic             stop_mode,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pullup,
  output logic [WIDTH-1:0] sync_in
);
  logic [WIDTH-1:0] latch_q, stage_q, pull_q, data_bits;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .latch_q(latch_q), .stage_q(stage_q), .pull_q(pull_q)
  );

  gpio_port_drive #(.WIDTH(WIDTH)) u_drive (
    .latch_q(latch_q), .stage_q(stage_q), .alt_sel(alt_sel), .alt_out(alt_out),
    .stop(stop_mode), .data_bits(data_bits), .oe(pad_oe), .out(pad_out)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(stop_mode), .d(pad_in), .q(sync_in)
  );

  assign pad_pullup = pull_q;

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      SEL_LATCH: reg_rdata = latch_q;
      SEL_STAGE: reg_rdata = stage_q;
      SEL_PULL:  reg_rdata = pull_q;
      default:   reg_rdata = sync_in;
    endcase
  end

  assert_od_never_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~stage_q & pad_out) == '0);
  assert_pp_always_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> (pad_oe & stage_q) == stage_q);
  assert_stop_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (pad_oe == '0 && pad_out == '0));
  assert_alt_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~latch_q) == '0);
endmodule

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;
  localparam int W = 5;
  logic clk = 0, rst_n = 0, reg_wr = 0, stop_mode = 0;
  logic [1:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, alt_sel = 0, alt_out = 0, pad_in = '1;
  logic [W-1:0] reg_rdata, pad_oe, pad_out, pad_pullup, sync_in;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_mux_port #(.WIDTH(W)) i_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_sel(alt_sel),
    .alt_out(alt_out), .stop_mode(stop_mode), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pullup(pad_pullup), .sync_in(sync_in)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // Independent model of the pad drive
  task automatic expect_pads(input logic [W-1:0] l, m, s, o, input logic st,
                             output logic [W-1:0] eoe, eout);
    for (int i = 0; i < W; i++) begin
      logic d;
      d = s[i] ? (o[i] && l[i]) : l[i];
      eoe[i]  = !st && (m[i] || !d);
      eout[i] = !st && m[i] && d;
    end
  endtask

  initial begin
    #50000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v, eoe, eout;
    repeat (3) @(negedge clk);
    // R1 reset values
    rd(0, v); check("R1 latch", v, '1);
    rd(1, v); check("R1 stage", v, '0);
    rd(2, v); check("R1 pull", v, '0);
    check("R1 oe", pad_oe, '0);
    rst_n = 1;
    @(negedge clk);

    // R2/R5 pull-up register
    wr(2, 5'b10110);
    rd(2, v); check("R2 pull readback", v, 5'b10110);
    check("R5 pad_pullup", pad_pullup, 5'b10110);

    // R3 R4 R8 exhaustive drive sweep
    for (int l = 0; l < 32; l++) begin
      wr(0, l[W-1:0]);
      rd(0, v); check("R2 latch readback", v, l[W-1:0]);
      for (int m = 0; m < 32; m++) begin
        wr(1, m[W-1:0]);
        for (int p = 0; p < 4; p++) begin
          alt_sel = (p == 0) ? 5'b00000 : (p == 1) ? 5'b11111 : (p == 2) ? 5'b01011 : 5'b10101;
          alt_out = (p == 1) ? 5'b01101 : (p == 2) ? 5'b00110 : 5'b11111;
          #1;
          expect_pads(l[W-1:0], m[W-1:0], alt_sel, alt_out, 1'b0, eoe, eout);
          check("R3/R4/R8 pad_oe", pad_oe, eoe);
          check("R3/R4/R8 pad_out", pad_out, eout);
        end
      end
    end
    alt_sel = 0; alt_out = 0;

    // R6 latch readback differs from pin
    wr(0, '1); wr(1, '0);
    pad_in = 5'b00000;
    repeat (3) @(negedge clk);
    rd(0, v); check("R6 latch not pin", v, '1);
    rd(3, v); check("R7 pin low", v, 5'b00000);

    // R7 two-edge latency
    pad_in = 5'b10101;
    @(negedge clk);
    rd(3, v); check("R7 one edge old", v, 5'b00000);
    @(negedge clk);
    rd(3, v); check("R7 two edges new", v, 5'b10101);
    check("R7 sync_in", sync_in, 5'b10101);

    // R11 write to pin address ignored
    wr(1, 5'b01100); wr(2, 5'b00011); wr(0, 5'b11010);
    wr(3, 5'b00101);
    rd(0, v); check("R11 latch", v, 5'b11010);
    rd(1, v); check("R11 stage", v, 5'b01100);
    rd(2, v); check("R11 pull", v, 5'b00011);

    // R9 R10 stop mode
    @(negedge clk); stop_mode = 1; #1;
    check("R9 stop oe", pad_oe, '0);
    check("R9 stop out", pad_out, '0);
    pad_in = 5'b01010;
    repeat (4) @(negedge clk);
    rd(3, v); check("R10 frozen pin", v, 5'b10101);
    check("R10 frozen sync", sync_in, 5'b10101);
    stop_mode = 0; #1;
    expect_pads(5'b11010, 5'b01100, '0, '0, 1'b0, eoe, eout);
    check("R9 resume oe", pad_oe, eoe);
    @(negedge clk);
    rd(3, v); check("R10 one edge after", v, 5'b10101);
    @(negedge clk);
    rd(3, v); check("R10 resumed", v, 5'b01010);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule